// File: doc/BRIEF.md
# Serial Memory Loader Monitor

This block lets a host computer fill, inspect and launch code in a 16-bit, byte-addressed memory over a plain asynchronous serial line with 8N1 framing and no handshake. It has its own receiver and transmitter, a command parser and a memory sequencer. Three one-character commands are accepted. A write command stores a stream of bytes. A read command sends a stream of bytes back. An execute command hands an address to a processor core through a start pulse.

Every command is followed by a 16-bit address, sent as two bytes with the high byte first. The write and read commands then take a 16-bit byte count in the same form. Byte accesses use the two lanes of the memory bus: address bit 0 picks the lane. Once an execute request is issued, the monitor waits for the core to report completion before it parses another command.

Top module: `ser_loader`

## Requirements
- R1: Serial frames carry one low start bit, 8 data bits with the least significant first, and one high stop bit. The line rests high. Each bit lasts round(CLK_HZ/BAUD) clock cycles, which is 87 at 10 MHz and 115200 baud.
- R2: Only the bytes 0x30 (write), 0x31 (read) and 0x32 (execute) start a command. Any other byte received while idle causes no bus cycle, no transmission and no start pulse.
- R3: The address and the count each arrive as two bytes, high byte first.
- R4: After a write header with count n, the next n received bytes are stored one by one at consecutive byte addresses, starting at the given address. Each store is one single-cycle write-enable pulse.
- R5: A byte store repeats the byte on both halves of mem_wdata_o. When address bit 0 is 1, only mem_we_o[0] (low lane, bits 7:0) is raised. When address bit 0 is 0, only mem_we_o[1] (high lane, bits 15:8) is raised. Both are never raised together.
- R6: After a read header with count n, n bytes are transmitted from consecutive byte addresses. mem_rdata_i is sampled in the cycle after mem_rd_o is high. Address bit 0 set returns bits 7:0; address bit 0 clear returns bits 15:8. A read and a write never happen in the same cycle.
- R7: A count of zero causes no memory access and no transmission, and the parser returns to idle.
- R8: An execute command raises run_o for exactly one cycle. run_addr_o carries the given address and keeps it until the next execute command.
- R9: After an execute request, every received byte is ignored until run_done_i is sampled high. After that the parser is idle.
- R10: A frame whose stop bit is sampled low is discarded. If a header or data byte was expected, the parser returns to idle.
- R11: After reset tx_o is high, and mem_rd_o, mem_we_o and run_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial data from the host |
| tx_o | output | 1 | Serial data to the host |
| mem_addr_o | output | AW | Byte address of the memory access |
| mem_rd_o | output | 1 | Read strobe |
| mem_we_o | output | 2 | Write enables: [1] high lane, [0] low lane |
| mem_wdata_o | output | 16 | Write data, with the byte repeated on both halves |
| mem_rdata_i | input | 16 | Read data, valid in the cycle after the strobe |
| run_o | output | 1 | One-cycle start request to the core |
| run_addr_o | output | AW | Start address for the core |
| run_done_i | input | 1 | Core reports that execution has finished |

## Verification
The bench builds the block with CLK_HZ = 50 MHz and BAUD = 3.125 Mbaud, so one bit lasts 16 cycles. With frames this short, a full sequence fits in the run: a write, read-backs at both lane parities, zero counts, stray characters, a broken stop bit and an execute handshake. The host side samples every transmitted bit at mid-bit using its own 16-cycle period, so any error in the derived bit period breaks the read-back values. AW stays at its default of 16, so the two-byte header fills the whole address.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  localparam logic [7:0] CMD_WR = 8'h30;
  localparam logic [7:0] CMD_RD = 8'h31;
  localparam logic [7:0] CMD_GO = 8'h32;

  typedef enum logic [3:0] {
    P_IDLE, P_AHI, P_ALO, P_LHI, P_LLO, P_WDAT,
    P_RREQ, P_RWAIT, P_RCAP, P_TXGO, P_TXWT, P_RUN, P_HOLD
  } pst_t;

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rxst_t;

  // Rounded clock cycles per serial bit.
  function automatic int unsigned bit_cycles(input int unsigned hz, input int unsigned baud);
    return (hz + baud / 2) / baud;
  endfunction

endpackage

// File: rtl/ldr_uart_rx.sv
module ldr_uart_rx #(
  parameter int BIT = 87
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_i,
  output logic       vld,
  output logic [7:0] byte_o,
  output logic       err
);
  import ldr_pkg::*;

  localparam int CW   = $clog2(BIT + 1);
  localparam int HALF = BIT / 2;

  logic [1:0]    sync;
  logic          rxs;
  rxst_t         st;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;

  assign rxs = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= 2'b11;
      st     <= R_IDLE;
      cnt    <= '0;
      nbit   <= '0;
      byte_o <= '0;
      vld    <= 1'b0;
      err    <= 1'b0;
    end else begin
      sync <= {sync[0], rx_i};
      vld  <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        R_IDLE: if (!rxs) begin
          cnt <= CW'(HALF - 1);
          st  <= R_START;
        end
        R_START: if (cnt == '0) begin
          if (!rxs) begin
            cnt  <= CW'(BIT - 1);
            nbit <= '0;
            st   <= R_DATA;
          end else begin
            st <= R_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        R_DATA: if (cnt == '0) begin
          byte_o <= {rxs, byte_o[7:1]};
          cnt    <= CW'(BIT - 1);
          nbit   <= nbit + 1'b1;
          if (nbit == 3'd7) st <= R_STOP;
        end else begin
          cnt <= cnt - 1'b1;
        end
        R_STOP: if (cnt == '0) begin
          if (rxs) vld <= 1'b1;
          else     err <= 1'b1;
          st <= R_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R10: a frame ends either accepted or rejected, never both
  a_r10_vld_xor_err: assert property (@(posedge clk) disable iff (rst) !(vld && err));
  // R1: a result only appears on the cycle that leaves the stop-bit phase
  a_r1_result_after_stop: assert property (@(posedge clk) disable iff (rst)
    (vld || err) |-> $past(st == R_STOP));

endmodule

// File: rtl/ldr_uart_tx.sv
module ldr_uart_tx #(
  parameter int BIT = 87
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] data,
  output logic       busy,
  output logic       tx_o
);
  localparam int CW = $clog2(BIT + 1);

  logic [8:0]    sh;
  logic [3:0]    left;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      tx_o <= 1'b1;
    end else if (!busy) begin
      if (go) begin
        sh   <= {1'b1, data};
        tx_o <= 1'b0;
        cnt  <= CW'(BIT - 1);
        left <= 4'd9;
        busy <= 1'b1;
      end
    end else if (cnt == '0) begin
      cnt <= CW'(BIT - 1);
      if (left == 4'd0) begin
        busy <= 1'b0;
      end else begin
        tx_o <= sh[0];
        sh   <= {1'b1, sh[8:1]};
        left <= left - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R1: the line rests high whenever no frame is in flight
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst) !busy |-> tx_o);
  // R1: every frame opens with a low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !tx_o);

endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_vld,
  input  logic [7:0]    rx_byte,
  input  logic          rx_err,
  input  logic          tx_busy,
  output logic          tx_go,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic [1:0]    mem_we_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          run_o,
  output logic [AW-1:0] run_addr_o,
  input  logic          run_done_i
);
  import ldr_pkg::*;

  pst_t          st;
  logic [7:0]    cmd;
  logic [7:0]    hold;
  logic [AW-1:0] ptr;
  logic [15:0]   cnt;
  logic [15:0]   word;
  logic          hdr_wait;

  assign word     = {hold, rx_byte};
  assign tx_go    = (st == P_TXGO);
  assign hdr_wait = (st == P_AHI) || (st == P_ALO) || (st == P_LHI) ||
                    (st == P_LLO) || (st == P_WDAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= P_IDLE;
      cmd         <= '0;
      hold        <= '0;
      ptr         <= '0;
      cnt         <= '0;
      tx_byte     <= '0;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_we_o    <= '0;
      mem_wdata_o <= '0;
      run_o       <= 1'b0;
      run_addr_o  <= '0;
    end else begin
      mem_rd_o <= 1'b0;
      mem_we_o <= '0;
      run_o    <= 1'b0;
      if (rx_err && hdr_wait) begin
        st <= P_IDLE;
      end else begin
        unique case (st)
          P_IDLE: if (rx_vld && (rx_byte == CMD_WR || rx_byte == CMD_RD || rx_byte == CMD_GO)) begin
            cmd <= rx_byte;
            st  <= P_AHI;
          end
          P_AHI: if (rx_vld) begin
            hold <= rx_byte;
            st   <= P_ALO;
          end
          P_ALO: if (rx_vld) begin
            ptr <= AW'(word);
            st  <= (cmd == CMD_GO) ? P_RUN : P_LHI;
          end
          P_LHI: if (rx_vld) begin
            hold <= rx_byte;
            st   <= P_LLO;
          end
          P_LLO: if (rx_vld) begin
            cnt <= word;
            if (word == 16'd0)      st <= P_IDLE;
            else if (cmd == CMD_WR) st <= P_WDAT;
            else                    st <= P_RREQ;
          end
          P_WDAT: if (rx_vld) begin
            mem_addr_o  <= ptr;
            mem_wdata_o <= {rx_byte, rx_byte};
            mem_we_o    <= ptr[0] ? 2'b01 : 2'b10;
            ptr         <= ptr + 1'b1;
            cnt         <= cnt - 16'd1;
            if (cnt == 16'd1) st <= P_IDLE;
          end
          P_RREQ: begin
            mem_addr_o <= ptr;
            mem_rd_o   <= 1'b1;
            st         <= P_RWAIT;
          end
          P_RWAIT: st <= P_RCAP;
          P_RCAP: begin
            tx_byte <= ptr[0] ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
            st      <= P_TXGO;
          end
          P_TXGO: st <= P_TXWT;
          P_TXWT: if (!tx_busy) begin
            ptr <= ptr + 1'b1;
            cnt <= cnt - 16'd1;
            st  <= (cnt == 16'd1) ? P_IDLE : P_RREQ;
          end
          P_RUN: begin
            run_o      <= 1'b1;
            run_addr_o <= ptr;
            st         <= P_HOLD;
          end
          P_HOLD: if (run_done_i) st <= P_IDLE;
          default: st <= P_IDLE;
        endcase
      end
    end
  end

  // R5: at most one byte lane is enabled
  a_r5_one_lane: assert property (@(posedge clk) disable iff (rst) $onehot0(mem_we_o));
  // R5: a store presents the same byte on both halves
  a_r5_dup_byte: assert property (@(posedge clk) disable iff (rst)
    (|mem_we_o) |-> (mem_wdata_o[15:8] == mem_wdata_o[7:0]));
  // R6: read and write never share a cycle
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst) !(mem_rd_o && (|mem_we_o)));
  // R8: the start request lasts one cycle
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst) run_o |=> !run_o);
  // R8: the start address stays put while the core runs
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (st == P_HOLD && $past(st == P_HOLD)) |-> $stable(run_addr_o));
  // R9: the bus stays quiet while waiting for the core
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == P_HOLD && $past(st == P_HOLD)) |-> (!mem_rd_o && mem_we_o == 2'b00));

endmodule

// File: rtl/ser_loader.sv
module ser_loader #(
  parameter int unsigned CLK_HZ = 10_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int          AW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_i,
  output logic          tx_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic [1:0]    mem_we_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          run_o,
  output logic [AW-1:0] run_addr_o,
  input  logic          run_done_i
);
  localparam int BIT = int'(ldr_pkg::bit_cycles(CLK_HZ, BAUD));

  logic       rx_vld, rx_err, tx_busy, tx_go;
  logic [7:0] rx_byte, tx_byte;

  ldr_uart_rx #(.BIT(BIT)) u_rx (
    .clk(clk), .rst(rst), .rx_i(rx_i),
    .vld(rx_vld), .byte_o(rx_byte), .err(rx_err)
  );

  ldr_uart_tx #(.BIT(BIT)) u_tx (
    .clk(clk), .rst(rst), .go(tx_go), .data(tx_byte),
    .busy(tx_busy), .tx_o(tx_o)
  );

  ldr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_err(rx_err),
    .tx_busy(tx_busy), .tx_go(tx_go), .tx_byte(tx_byte),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .run_o(run_o), .run_addr_o(run_addr_o), .run_done_i(run_done_i)
  );

endmodule

// File: tb/sim_ser_loader.sv
`timescale 1ns / 1ps
module sim_ser_loader;
  localparam int BIT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_i = 1'b1;
  logic        tx_o;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [1:0]  mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        run;
  logic [15:0] run_addr;
  logic        run_done = 1'b0;

  always #10 clk = ~clk;

  ser_loader #(.CLK_HZ(50_000_000), .BAUD(3_125_000), .AW(16)) u0 (
    .clk(clk), .rst(rst), .rx_i(rx_i), .tx_o(tx_o),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .run_o(run), .run_addr_o(run_addr), .run_done_i(run_done)
  );

  // memory model: 256 words, data one cycle after the strobe
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_we[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
    if (mem_we[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
    if (mem_rd)    mem_rdata <= mem[mem_addr[8:1]];
  end

  int checks = 0, errors = 0;
  int we_cnt = 0, rd_cnt = 0, lane_bad = 0, half_bad = 0, run_cnt = 0, run_wide = 0;
  logic run_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst) begin
      if (|mem_we) we_cnt++;
      if (mem_we == 2'b11) lane_bad++;
      if ((|mem_we) && (mem_wdata[15:8] != mem_wdata[7:0])) half_bad++;
      if (mem_rd) rd_cnt++;
      if (run) begin
        run_cnt++;
        if (run_prev) run_wide++;
      end
      run_prev <= run;
    end
  end

  // host-side receiver, mid-bit sampling with the bench's own period
  logic [7:0] cap [0:63];
  int ncap = 0;
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (tx_o === 1'b0) begin
        repeat (BIT / 2) @(negedge clk);
        b = '0;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = tx_o;
        end
        repeat (BIT) @(negedge clk);
        if (ncap < 64) cap[ncap] = b;
        ncap++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_i = 1'b0; wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i]; wait_cyc(BIT);
    end
    rx_i = 1'b1; wait_cyc(3 * BIT);
  endtask

  task automatic send_bad(input logic [7:0] b);
    rx_i = 1'b0; wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i]; wait_cyc(BIT);
    end
    rx_i = 1'b0; wait_cyc(BIT);
    rx_i = 1'b1; wait_cyc(14 * BIT);
  endtask

  task automatic send_hdr(input logic [7:0] c, input logic [15:0] a, input logic [15:0] n);
    send(c);
    send(a[15:8]); send(a[7:0]);
    send(n[15:8]); send(n[7:0]);
  endtask

  task automatic t_reset;
    check(tx_o === 1'b1 && mem_rd === 1'b0 && mem_we === 2'b00 && run === 1'b0,
          "R11 reset outputs", {tx_o, mem_rd, mem_we, run}, 5'b10000);
  endtask

  task automatic t_write;
    send_hdr(8'h30, 16'h0040, 16'd4);
    send(8'h12); send(8'h34); send(8'h56); send(8'h78);
    wait_cyc(20);
    check(mem[8'h20] == 16'h1234, "R4 R3 word 0x40", mem[8'h20], 16'h1234);
    check(mem[8'h21] == 16'h5678, "R4 word 0x42", mem[8'h21], 16'h5678);
    check(we_cnt == 4, "R4 store count", we_cnt, 4);
    check(lane_bad == 0 && half_bad == 0, "R5 lane use", lane_bad + half_bad, 0);
  endtask

  task automatic t_read;
    ncap = 0;
    send_hdr(8'h31, 16'h0041, 16'd3);
    wait_cyc(3 * 12 * BIT + 100);
    check(ncap == 3, "R6 byte count", ncap, 3);
    check(cap[0] == 8'h34, "R6 R1 odd address low byte", cap[0], 8'h34);
    check(cap[1] == 8'h56, "R6 even address high byte", cap[1], 8'h56);
    check(cap[2] == 8'h78, "R6 consecutive address", cap[2], 8'h78);
    ncap = 0;
    send_hdr(8'h31, 16'h0040, 16'd1);
    wait_cyc(12 * BIT + 100);
    check(ncap == 1 && cap[0] == 8'h12, "R6 single even read", cap[0], 8'h12);
  endtask

  task automatic t_zero;
    int r0, w0;
    r0 = rd_cnt; w0 = we_cnt; ncap = 0;
    send_hdr(8'h31, 16'h0040, 16'd0);
    wait_cyc(12 * BIT);
    check(ncap == 0 && rd_cnt == r0, "R7 zero-count read", rd_cnt - r0, 0);
    send_hdr(8'h30, 16'h0050, 16'd0);
    send(8'hEE);
    wait_cyc(20);
    check(we_cnt == w0, "R7 zero-count write then idle", we_cnt - w0, 0);
  endtask

  task automatic t_ignore;
    int r0, w0, g0;
    r0 = rd_cnt; w0 = we_cnt; g0 = run_cnt; ncap = 0;
    send(8'h41); send(8'h33); send(8'h2F);
    wait_cyc(12 * BIT);
    check(ncap == 0 && rd_cnt == r0 && we_cnt == w0 && run_cnt == g0,
          "R2 stray characters", ncap + rd_cnt - r0 + we_cnt - w0, 0);
    send_hdr(8'h31, 16'h0041, 16'd1);
    wait_cyc(12 * BIT + 100);
    check(ncap == 1 && cap[0] == 8'h34, "R2 idle after stray", cap[0], 8'h34);
  endtask

  task automatic t_frame;
    ncap = 0;
    send(8'h31);
    send_bad(8'h00);
    send_hdr(8'h31, 16'h0043, 16'd1);
    wait_cyc(12 * BIT + 100);
    check(ncap == 1, "R10 parser reset by bad stop", ncap, 1);
    check(cap[0] == 8'h78, "R10 fresh command data", cap[0], 8'h78);
  endtask

  task automatic t_exec;
    int w0;
    send(8'h32); send(8'hBE); send(8'hEF);
    wait_cyc(20);
    check(run_cnt == 1 && run_wide == 0, "R8 one start pulse", run_cnt, 1);
    check(run_addr == 16'hBEEF, "R8 start address", run_addr, 16'hBEEF);
    w0 = we_cnt;
    send_hdr(8'h30, 16'h0060, 16'd1);
    send(8'hAB);
    wait_cyc(20);
    check(we_cnt == w0 && run_cnt == 1, "R9 bytes ignored while running", we_cnt - w0, 0);
    run_done = 1'b1; wait_cyc(1); run_done = 1'b0;
    wait_cyc(5);
    check(run_addr == 16'hBEEF, "R8 address kept after done", run_addr, 16'hBEEF);
    ncap = 0;
    send_hdr(8'h31, 16'h0040, 16'd1);
    wait_cyc(12 * BIT + 100);
    check(ncap == 1 && cap[0] == 8'h12, "R9 idle after done", cap[0], 8'h12);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);
    t_reset;
    t_write;
    t_read;
    t_zero;
    t_ignore;
    t_frame;
    t_exec;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule